// File: doc/BRIEF.md
# Head Positioning Step Sequencer

This block runs the head-positioning commands of a floppy disk controller. A one-cycle start strobe delivers a command byte, the current track value and a seek target. The block then drives a step pulse and a direction line toward the drive, spacing the pulses at one of four programmable intervals. It watches the drive's track-zero sensor and keeps its own copy of the track number. The status logic receives busy, seek error, head-loaded and track-zero indications from it.

Five commands are supported. Restore moves the head outward until the sensor reports track zero. Seek moves the head until the track number equals the target. The three single-step commands move one track inward, one track outward, or one track in the last direction used. Option bits in the command byte control head loading, the destination check, track-number updates for the single steps, and the step interval. The destination check is not computed here. It arrives as a pass/fail input and is sampled as the command completes.

Top module: `head_pos_seq`

## Requirements
- R1: While reset is asserted and just after it, busy_o, step_o, seek_err_o, head_load_o and done_o are 0, track_o is 0, and dir_o is 1 (inward).
- R2: A start_i strobe while idle is accepted only when cmd_i[7] is 0, and busy_o rises in the next cycle. Otherwise busy_o stays 0 and done_o does not pulse. The opcode is decoded as follows: cmd_i[7:4] = 0000 restore, 0001 seek, 001u step, 010u step in, 011u step out.
- R3: head_load_o takes the value of cmd_i[3] in the cycle after an accepted start, and it holds that value after the command ends.
- R4: cmd_i[1:0] selects the interval RATE_0..RATE_3, counted in clock cycles between the rising edges of consecutive step pulses within one command. Each pulse is high for PULSE_W cycles, and step_o is high only while busy_o is high.
- R5: dir_o stays unchanged in the cycle before step_o rises and for as long as step_o is high (1 = inward, 0 = outward).
- R6: Step in sets dir_o to 1 and step out sets it to 0. Plain step keeps the current dir_o. Each of these issues one pulse. It changes track_o by +1 (inward) or -1 (outward) only when cmd_i[4] is 1; otherwise track_o is unchanged.
- R7: Seek loads track_o from track_i. It then steps toward target_i, adjusting track_o by one per pulse until they are equal, and issues no pulse when they are already equal.
- R8: Restore steps outward until trk0_i is seen high before a step would be issued, and then sets track_o to 0. After 255 steps without it, the command ends with seek_err_o set.
- R9: When cmd_i[2] is 1, seek_err_o is set at completion if verify_ok_i is 0. When cmd_i[2] is 0, verify_ok_i has no effect. seek_err_o clears at each accepted start.
- R10: Every command ends with busy_o falling and done_o high for exactly one cycle.
- R11: A cycle with abort_i high makes the next cycle show busy_o 0, step_o 0 and done_o 1, whether the block is busy or idle. Abort takes priority over start.
- R12: trk0_o follows trk0_i with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command start strobe |
| cmd_i | input | 8 | Command byte: opcode and option bits |
| track_i | input | TRACK_W | Current track number, loaded on start |
| target_i | input | TRACK_W | Seek destination |
| trk0_i | input | 1 | Track-zero sensor from the drive |
| verify_ok_i | input | 1 | Result of the destination check, 1 = pass |
| abort_i | input | 1 | Ends the current command at once |
| step_o | output | 1 | Step pulse to the drive |
| dir_o | output | 1 | Step direction, 1 = inward |
| track_o | output | TRACK_W | Updated track number |
| busy_o | output | 1 | Command in progress |
| seek_err_o | output | 1 | Seek or destination error |
| head_load_o | output | 1 | Head load request |
| trk0_o | output | 1 | Registered track-zero status |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Several properties are checked by the assertions on every cycle. These are the direction setup and hold around each step pulse, step pulses appearing only while busy, the done pulse landing only while idle, abort ending a command in one cycle, and the acceptance or rejection of a start strobe together with the head-load value it latches. Other behaviours can only be shown by the bench's scenarios against its reference model. These are the exact pulse spacing for each rate code, the track arithmetic of each command, the sensor-terminated and 255-step restore, and the effect of the verify input with the check option on and off.

// File: rtl/hps_pkg.sv
package hps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_SETUP,
    ST_RUN,
    ST_FIN
  } hps_state_e;

  typedef enum logic [2:0] {
    OP_RESTORE,
    OP_SEEK,
    OP_STEP,
    OP_STEP_IN,
    OP_STEP_OUT,
    OP_NONE
  } hps_op_e;

  typedef struct packed {
    hps_op_e    op;
    logic       load_head;
    logic       verify;
    logic       upd;
    logic [1:0] rate;
  } hps_cmd_t;

  function automatic hps_cmd_t hps_decode(input logic [7:0] c);
    hps_cmd_t d;
    d.load_head = c[3];
    d.verify    = c[2];
    d.rate      = c[1:0];
    d.upd       = 1'b1;
    d.op        = OP_NONE;
    if (!c[7]) begin
      case (c[6:5])
        2'b00: d.op = c[4] ? OP_SEEK : OP_RESTORE;
        2'b01: begin d.op = OP_STEP;     d.upd = c[4]; end
        2'b10: begin d.op = OP_STEP_IN;  d.upd = c[4]; end
        default: begin d.op = OP_STEP_OUT; d.upd = c[4]; end
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/hps_step_timer.sv
module hps_step_timer #(
  parameter int unsigned RATE_0 = 6000,
  parameter int unsigned RATE_1 = 3328,
  parameter int unsigned RATE_2 = 1664,
  parameter int unsigned RATE_3 = 832
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [1:0] sel_i,
  output logic       expired_o
);
  localparam int unsigned RMAX_A = (RATE_0 > RATE_1) ? RATE_0 : RATE_1;
  localparam int unsigned RMAX_B = (RATE_2 > RATE_3) ? RATE_2 : RATE_3;
  localparam int unsigned RMAX   = (RMAX_A > RMAX_B) ? RMAX_A : RMAX_B;
  localparam int unsigned CW     = $clog2(RMAX + 1);
  localparam int unsigned RATES [4] = '{RATE_0, RATE_1, RATE_2, RATE_3};

  logic [CW-1:0] reload [4];
  logic [CW-1:0] cnt_q;

  // eval and setup cycles are part of the interval
  for (genvar g = 0; g < 4; g++) begin : g_reload
    assign reload[g] = CW'(RATES[g] - 3);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= reload[sel_i];
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/hps_step_pulse.sv
module hps_step_pulse #(
  parameter int unsigned PULSE_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic kill_i,
  output logic step_o
);
  localparam int unsigned PW = (PULSE_W < 2) ? 1 : $clog2(PULSE_W);

  logic [PW-1:0] left_q;
  logic          step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= 1'b0;
      left_q <= '0;
    end else if (kill_i) begin
      step_q <= 1'b0;
      left_q <= '0;
    end else if (fire_i) begin
      step_q <= 1'b1;
      left_q <= PW'(PULSE_W - 1);
    end else if (step_q) begin
      if (left_q == '0) step_q <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end

  assign step_o = step_q;
endmodule

// File: rtl/hps_seq_ctrl.sv
module hps_seq_ctrl
  import hps_pkg::*;
#(
  parameter int unsigned TRACK_W       = 8,
  parameter int unsigned RESTORE_LIMIT = 255
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [7:0]         cmd_i,
  input  logic [TRACK_W-1:0] track_i,
  input  logic [TRACK_W-1:0] target_i,
  input  logic               trk0_i,
  input  logic               verify_ok_i,
  input  logic               abort_i,
  input  logic               tmr_expired_i,
  output logic               fire_o,
  output logic [1:0]         rate_o,
  output logic               dir_o,
  output logic [TRACK_W-1:0] track_o,
  output logic               busy_o,
  output logic               seek_err_o,
  output logic               head_load_o,
  output logic               done_o
);
  localparam int unsigned CNTW = $clog2(RESTORE_LIMIT + 1);

  hps_state_e         state_q;
  hps_cmd_t           cmd_q, cmd_dec;
  logic [TRACK_W-1:0] track_q, tgt_q;
  logic [CNTW-1:0]    cnt_q;
  logic               taken_q, dir_q, busy_q, err_q, head_q, done_q;
  logic               want_step, want_dir, zero_trk, limit_err;

  assign cmd_dec = hps_decode(cmd_i);

  always_comb begin
    want_step = 1'b0;
    want_dir  = dir_q;
    zero_trk  = 1'b0;
    limit_err = 1'b0;
    case (cmd_q.op)
      OP_RESTORE: begin
        if (trk0_i)                                zero_trk  = 1'b1;
        else if (cnt_q == CNTW'(RESTORE_LIMIT))    limit_err = 1'b1;
        else begin
          want_step = 1'b1;
          want_dir  = 1'b0;
        end
      end
      OP_SEEK: begin
        if (track_q != tgt_q) begin
          want_step = 1'b1;
          want_dir  = (tgt_q > track_q);
        end
      end
      OP_STEP:     want_step = !taken_q;
      OP_STEP_IN:  begin want_step = !taken_q; want_dir = 1'b1; end
      OP_STEP_OUT: begin want_step = !taken_q; want_dir = 1'b0; end
      default:     want_step = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '{op: OP_NONE, load_head: 1'b0, verify: 1'b0, upd: 1'b0, rate: 2'd0};
      track_q <= '0;
      tgt_q   <= '0;
      cnt_q   <= '0;
      taken_q <= 1'b0;
      dir_q   <= 1'b1;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      head_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        state_q <= ST_IDLE;
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (start_i && cmd_dec.op != OP_NONE) begin
              cmd_q   <= cmd_dec;
              tgt_q   <= target_i;
              track_q <= track_i;
              cnt_q   <= '0;
              taken_q <= 1'b0;
              busy_q  <= 1'b1;
              head_q  <= cmd_dec.load_head;
              err_q   <= 1'b0;
              state_q <= ST_EVAL;
            end
          end
          ST_EVAL: begin
            if (zero_trk)  track_q <= '0;
            if (limit_err) err_q   <= 1'b1;
            if (want_step) begin
              dir_q   <= want_dir;
              state_q <= ST_SETUP;
            end else begin
              state_q <= ST_FIN;
            end
          end
          ST_SETUP: begin
            taken_q <= 1'b1;
            cnt_q   <= cnt_q + 1'b1;
            if (cmd_q.upd)
              track_q <= dir_q ? track_q + TRACK_W'(1) : track_q - TRACK_W'(1);
            state_q <= ST_RUN;
          end
          ST_RUN: begin
            if (tmr_expired_i) state_q <= ST_EVAL;
          end
          ST_FIN: begin
            if (cmd_q.verify && !verify_ok_i) err_q <= 1'b1;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign fire_o      = (state_q == ST_SETUP) && !abort_i;
  assign rate_o      = cmd_q.rate;
  assign dir_o       = dir_q;
  assign track_o     = track_q;
  assign busy_o      = busy_q;
  assign seek_err_o  = err_q;
  assign head_load_o = head_q;
  assign done_o      = done_q;
endmodule

// File: rtl/head_pos_seq.sv
module head_pos_seq #(
  parameter int unsigned TRACK_W       = 8,
  parameter int unsigned RATE_0        = 6000,
  parameter int unsigned RATE_1        = 3328,
  parameter int unsigned RATE_2        = 1664,
  parameter int unsigned RATE_3        = 832,
  parameter int unsigned PULSE_W       = 4,
  parameter int unsigned RESTORE_LIMIT = 255
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [7:0]         cmd_i,
  input  logic [TRACK_W-1:0] track_i,
  input  logic [TRACK_W-1:0] target_i,
  input  logic               trk0_i,
  input  logic               verify_ok_i,
  input  logic               abort_i,
  output logic               step_o,
  output logic               dir_o,
  output logic [TRACK_W-1:0] track_o,
  output logic               busy_o,
  output logic               seek_err_o,
  output logic               head_load_o,
  output logic               trk0_o,
  output logic               done_o
);
  logic       fire, expired;
  logic [1:0] rate_sel;
  logic       trk0_q;

  hps_seq_ctrl #(
    .TRACK_W      (TRACK_W),
    .RESTORE_LIMIT(RESTORE_LIMIT)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .cmd_i        (cmd_i),
    .track_i      (track_i),
    .target_i     (target_i),
    .trk0_i       (trk0_i),
    .verify_ok_i  (verify_ok_i),
    .abort_i      (abort_i),
    .tmr_expired_i(expired),
    .fire_o       (fire),
    .rate_o       (rate_sel),
    .dir_o        (dir_o),
    .track_o      (track_o),
    .busy_o       (busy_o),
    .seek_err_o   (seek_err_o),
    .head_load_o  (head_load_o),
    .done_o       (done_o)
  );

  hps_step_timer #(
    .RATE_0(RATE_0), .RATE_1(RATE_1), .RATE_2(RATE_2), .RATE_3(RATE_3)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (fire),
    .sel_i    (rate_sel),
    .expired_o(expired)
  );

  hps_step_pulse #(
    .PULSE_W(PULSE_W)
  ) u_pulse (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fire_i(fire),
    .kill_i(abort_i),
    .step_o(step_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trk0_q <= 1'b0;
    else         trk0_q <= trk0_i;
  end

  assign trk0_o = trk0_q;
endmodule

// File: rtl/hps_checker.sv
module hps_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [7:0] cmd_i,
  input logic       abort_i,
  input logic       step_o,
  input logic       dir_o,
  input logic       busy_o,
  input logic       head_load_o,
  input logic       done_o
);
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && cmd_i[7]) |=> !busy_o); // R2

  AST_HEAD_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !cmd_i[7] && !abort_i) |=> (busy_o && head_load_o == $past(cmd_i[3]))); // R3

  AST_STEP_IN_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> busy_o); // R4

  AST_DIR_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(step_o) |-> $stable(dir_o)); // R5

  AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && $past(step_o)) |-> $stable(dir_o)); // R5

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R10

  AST_ABORT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && !step_o && done_o)); // R11
endmodule

bind head_pos_seq hps_checker u_chk (.*);

// File: tb/head_pos_seq_tb.sv
module head_pos_seq_tb;
  localparam int PW = 2;
  int rates [4] = '{5, 6, 8, 11};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, trk0 = 1'b0, vok = 1'b1, abort = 1'b0;
  logic [7:0] cmd = 8'h00, trk_in = 8'h00, tgt = 8'h00;
  logic       step_o, dir_o, busy_o, seek_err_o, head_load_o, trk0_o, done_o;
  logic [7:0] track_o;

  int checks = 0, errors = 0, cyc = 0;
  int rise_q [$];
  logic step_prev = 1'b0;

  always #2 clk = ~clk;

  head_pos_seq #(
    .TRACK_W(8), .RATE_0(5), .RATE_1(6), .RATE_2(8), .RATE_3(11),
    .PULSE_W(PW), .RESTORE_LIMIT(255)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd), .track_i(trk_in),
    .target_i(tgt), .trk0_i(trk0), .verify_ok_i(vok), .abort_i(abort),
    .step_o(step_o), .dir_o(dir_o), .track_o(track_o), .busy_o(busy_o),
    .seek_err_o(seek_err_o), .head_load_o(head_load_o), .trk0_o(trk0_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_ph, m_tm, m_pw, m_cnt;
  bit m_taken, m_go, m_d;
  logic [7:0] m_cmd, m_tgt, e_trk;
  logic e_step, e_dir, e_busy, e_err, e_head, e_done, e_trk0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_tm = 0; m_pw = 0; m_cnt = 0; m_taken = 0;
      m_cmd = 0; m_tgt = 0; e_trk = 0;
      e_step = 0; e_dir = 1; e_busy = 0; e_err = 0; e_head = 0; e_done = 0; e_trk0 = 0;
    end else begin
      e_done = 0;
      e_trk0 = trk0;
      if (e_step) begin
        if (m_pw == 0) e_step = 0; else m_pw--;
      end
      if (abort) begin
        e_busy = 0; e_step = 0; e_done = 1; m_ph = 0;
      end else begin
        case (m_ph)
          0: if (start && !cmd[7]) begin
            m_cmd = cmd; m_tgt = tgt; e_trk = trk_in; e_busy = 1; e_head = cmd[3];
            e_err = 0; m_cnt = 0; m_taken = 0; m_ph = 1;
          end
          1: begin
            m_go = 0; m_d = e_dir;
            if (m_cmd[6:4] == 3'b000) begin
              if (trk0) e_trk = 0;
              else if (m_cnt == 255) e_err = 1;
              else begin m_go = 1; m_d = 0; end
            end else if (m_cmd[6:4] == 3'b001) begin
              if (e_trk != m_tgt) begin m_go = 1; m_d = (m_tgt > e_trk); end
            end else begin
              m_go = !m_taken;
              if (m_cmd[6:5] == 2'b10) m_d = 1;
              if (m_cmd[6:5] == 2'b11) m_d = 0;
            end
            if (m_go) begin e_dir = m_d; m_ph = 2; end else m_ph = 4;
          end
          2: begin
            e_step = 1; m_pw = PW - 1; m_tm = rates[m_cmd[1:0]] - 3;
            m_taken = 1; m_cnt++;
            if (m_cmd[6:5] == 2'b00 || m_cmd[4]) e_trk = e_dir ? e_trk + 8'd1 : e_trk - 8'd1;
            m_ph = 3;
          end
          3: if (m_tm == 0) m_ph = 1; else m_tm--;
          default: begin
            if (m_cmd[2] && !vok) e_err = 1;
            e_busy = 0; e_done = 1; m_ph = 0;
          end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 step_o", step_o, e_step);
      chk("R5 dir_o", dir_o, e_dir);
      chk("R6 track_o", track_o, e_trk);
      chk("R10 busy_o", busy_o, e_busy);
      chk("R9 seek_err_o", seek_err_o, e_err);
      chk("R3 head_load_o", head_load_o, e_head);
      chk("R10 done_o", done_o, e_done);
      chk("R12 trk0_o", trk0_o, e_trk0);
      if (step_o && !step_prev) rise_q.push_back(cyc);
    end
    step_prev = step_o;
  end

  task automatic run_cmd(input logic [7:0] c, input logic [7:0] t, input logic v);
    int n;
    @(negedge clk);
    rise_q.delete();
    cmd = c; tgt = t; trk_in = track_o; vok = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done_o && n < 5000) begin @(negedge clk); n++; end
    chk("R10 done seen", done_o, 1'b1);
    @(negedge clk);
    chk("R10 done one cycle", done_o, 1'b0);
  endtask

  task automatic chk_gaps(input string tag, input int r);
    for (int i = 1; i < rise_q.size(); i++) chk(tag, rise_q[i] - rise_q[i-1], r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy_o, 1'b0);
    chk("R1 step", step_o, 1'b0);
    chk("R1 dir", dir_o, 1'b1);
    chk("R1 track", track_o, 8'd0);
    chk("R1 err", seek_err_o, 1'b0);
    chk("R1 done", done_o, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: non-positioning opcode ignored
    cmd = 8'h80; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) begin
      chk("R2 ignored busy", busy_o, 1'b0);
      chk("R2 ignored done", done_o, 1'b0);
      @(negedge clk);
    end

    // R7 seek 0->5 rate 0
    run_cmd(8'h10, 8'd5, 1'b1);
    chk("R7 seek track", track_o, 8'd5);
    chk("R7 seek steps", rise_q.size(), 5);
    chk_gaps("R4 gap rate0", 5);

    // R6 step in with update, head load
    run_cmd(8'h58, 8'd0, 1'b1);
    chk("R6 step in track", track_o, 8'd6);
    chk("R6 step in dir", dir_o, 1'b1);
    chk("R3 head set", head_load_o, 1'b1);
    chk("R6 one pulse", rise_q.size(), 1);

    run_cmd(8'h30, 8'd0, 1'b1);
    chk("R6 step repeats in", track_o, 8'd7);

    run_cmd(8'h61, 8'd0, 1'b1);
    chk("R6 step out no update", track_o, 8'd7);
    chk("R6 step out dir", dir_o, 1'b0);

    run_cmd(8'h30, 8'd0, 1'b1);
    chk("R6 step repeats out", track_o, 8'd6);

    // R9 verify pass, rate 2
    run_cmd(8'h16, 8'd10, 1'b1);
    chk("R7 seek up", track_o, 8'd10);
    chk("R9 verify pass", seek_err_o, 1'b0);
    chk_gaps("R4 gap rate2", 8);

    // R9 verify fail, rate 3
    run_cmd(8'h1F, 8'd2, 1'b0);
    chk("R7 seek down", track_o, 8'd2);
    chk("R9 verify fail", seek_err_o, 1'b1);
    chk_gaps("R4 gap rate3", 11);

    // R9 verify off ignores result; R7 zero steps; R3 head clear
    run_cmd(8'h11, 8'd2, 1'b0);
    chk("R7 no steps", rise_q.size(), 0);
    chk("R9 verify off", seek_err_o, 1'b0);
    chk("R3 head clear", head_load_o, 1'b0);

    // R8 restore ending on sensor after 4 steps
    fork
      run_cmd(8'h00, 8'd0, 1'b1);
      begin
        repeat (4) @(posedge step_o);
        @(negedge clk); trk0 = 1'b1;
      end
    join
    chk("R8 restore track", track_o, 8'd0);
    chk("R8 restore steps", rise_q.size(), 4);
    chk("R8 restore no err", seek_err_o, 1'b0);
    chk("R8 restore dir out", dir_o, 1'b0);
    chk("R12 trk0 status", trk0_o, 1'b1);
    trk0 = 1'b0;

    // R8 restore timeout
    run_cmd(8'h00, 8'd0, 1'b1);
    chk("R8 timeout steps", rise_q.size(), 255);
    chk("R8 timeout err", seek_err_o, 1'b1);

    // R11 abort during seek
    @(negedge clk);
    cmd = 8'h10; tgt = 8'd60; trk_in = track_o; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (12) @(negedge clk);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk("R11 abort busy", busy_o, 1'b0);
    chk("R11 abort step", step_o, 1'b0);
    chk("R11 abort done", done_o, 1'b1);

    // R11 abort while idle
    repeat (3) @(negedge clk);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk("R11 idle abort done", done_o, 1'b1);
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule